// File: doc/BRIEF.md
# Multi-Input Edge Timestamp Capture Unit

This unit keeps a free-running cycle counter and watches a small set of asynchronous pulse lines, one per peer channel. Each line is brought into the clock domain through a short flip-flop chain, and its transitions are detected there. The counter value at each transition is written into a register for that line. Rising and falling transitions go into separate registers, so software can recover both the high time and the low time of the most recent pulse from every sender. Senders can therefore carry a small amount of state in the duty ratio of their pulses.

Each line has two sticky flags, one recording that a rising edge was stored and one recording that a falling edge was stored. Software clears them by writing ones. A snapshot request copies the whole counter into a holding register in a single cycle. Software can then read a wide value coherently and relate it to an unrelated processor timer. The default build has three lines, so a channel can loop its own output back as a monitor.

Top module: `edge_stamp_unit`

## Requirements
- R1: The counter is TS_W bits wide (default 32). It is 0 while `rst` is high, increases by exactly one on every clock edge after that, and wraps from all-ones to 0.
- R2: Each line passes through SYNC_STAGES flip-flops (default 2) before edge detection. If a line changes before clock edge k, the stored stamp equals the counter value held just before edge k+SYNC_STAGES, and the stamp is readable after that edge.
- R3: Input i's rising edges are stored only in slice i of `rise_stamp`, and its falling edges only in slice i of `fall_stamp`. Slice i occupies bits [i*TS_W +: TS_W].
- R4: A new edge of one kind overwrites the previous stamp of that kind on that line. Only the latest edge is kept.
- R5: An edge on one line leaves unchanged the stamps of every other line and the opposite-kind stamp of the same line.
- R6: Bit i of `rise_flag` or `fall_flag` is set in the same cycle that its stamp is written. It then stays set until it is cleared.
- R7: A one on bit i of `rise_clr` or `fall_clr` for one cycle clears that flag at the next edge. Zero bits leave their flags untouched.
- R8: If a clear and a capture for the same flag fall in the same cycle, the flag ends up set.
- R9: While `snap_req` is high in a cycle, `snap_value` takes the counter value of that cycle at the next edge. While `snap_req` is low, `snap_value` holds.
- R10: After reset, every stamp, every flag and `snap_value` read 0.
- R11: For a pulse on one line, (fall stamp − rise stamp) modulo 2^TS_W equals the pulse width in clock cycles, including when the counter wraps inside the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_in | input | NUM_IN | Asynchronous pulse lines, one per peer |
| snap_req | input | 1 | Copy the counter into `snap_value` |
| rise_clr | input | NUM_IN | Write-one-to-clear for the rising-edge flags |
| fall_clr | input | NUM_IN | Write-one-to-clear for the falling-edge flags |
| rise_stamp | output | NUM_IN*TS_W | Latest rising-edge stamp of each line |
| fall_stamp | output | NUM_IN*TS_W | Latest falling-edge stamp of each line |
| rise_flag | output | NUM_IN | Sticky: a rising edge was stored |
| fall_flag | output | NUM_IN | Sticky: a falling edge was stored |
| snap_value | output | TS_W | Coherent counter snapshot |

## Verification
The capture path is driven with a single pulse on one line, then with all three lines rising together and falling at different times. That second pattern shows whether each line keeps its own stamps and whether the high durations differ as encoded. Repeated pulses on one line separate overwrite from keep-first behaviour. A pulse timed across the counter wrap shows whether modular duration recovery holds. Clear pulses are applied once alone and once in the capture cycle, which separates plain clearing from the set-wins rule. Snapshots taken back to back and some cycles apart tie the counter step to the snapshot timing.

// File: rtl/est_pkg.sv
package est_pkg;

  // One detected transition of a synchronized line.
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_evt_t;

  // Stamp kind, used to index the two stamp registers of a line.
  typedef enum logic {
    KIND_RISE = 1'b0,
    KIND_FALL = 1'b1
  } stamp_kind_e;

endpackage

// File: rtl/est_counter.sv
module est_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] STEP = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count + STEP;  // modulo 2^W by width
  end

endmodule

// File: rtl/est_input_sync.sv
module est_input_sync
  import est_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      din,
  output edge_evt_t evt
);

  logic [STAGES-1:0] chain;
  logic              settled;
  logic              last;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign settled = chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) last <= 1'b0;
    else     last <= settled;
  end

  always_comb begin
    evt.rise = settled & ~last;
    evt.fall = ~settled & last;
  end

endmodule

// File: rtl/est_stamp_slot.sv
module est_stamp_slot
  import est_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  edge_evt_t    evt,
  input  logic [W-1:0] now,
  input  logic         clr_rise,
  input  logic         clr_fall,
  output logic [W-1:0] rise_ts,
  output logic [W-1:0] fall_ts,
  output logic         rise_seen,
  output logic         fall_seen
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_ts <= '0;
      fall_ts <= '0;
    end else begin
      if (evt.rise) rise_ts <= now;
      if (evt.fall) fall_ts <= now;
    end
  end

  // Sticky flags: a capture outranks a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      rise_seen <= 1'b0;
      fall_seen <= 1'b0;
    end else begin
      if (evt.rise)     rise_seen <= 1'b1;
      else if (clr_rise) rise_seen <= 1'b0;
      if (evt.fall)     fall_seen <= 1'b1;
      else if (clr_fall) fall_seen <= 1'b0;
    end
  end

endmodule

// File: rtl/est_snapshot.sv
module est_snapshot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         take,
  input  logic [W-1:0] now,
  output logic [W-1:0] held
);

  always_ff @(posedge clk) begin
    if (rst)       held <= '0;
    else if (take) held <= now;
  end

endmodule

// File: rtl/edge_stamp_unit.sv
module edge_stamp_unit
  import est_pkg::*;
#(
  parameter int NUM_IN      = 3,
  parameter int TS_W        = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_IN-1:0]      pulse_in,
  input  logic                   snap_req,
  input  logic [NUM_IN-1:0]      rise_clr,
  input  logic [NUM_IN-1:0]      fall_clr,
  output logic [NUM_IN*TS_W-1:0] rise_stamp,
  output logic [NUM_IN*TS_W-1:0] fall_stamp,
  output logic [NUM_IN-1:0]      rise_flag,
  output logic [NUM_IN-1:0]      fall_flag,
  output logic [TS_W-1:0]        snap_value
);

  localparam int STAMP_BITS = NUM_IN * TS_W;

  logic [TS_W-1:0]   count;
  logic [NUM_IN-1:0] rise_det;
  logic [NUM_IN-1:0] fall_det;
  logic [STAMP_BITS-1:0] rise_bus;
  logic [STAMP_BITS-1:0] fall_bus;

  est_counter #(.W(TS_W)) u_count (
    .clk   (clk),
    .rst   (rst),
    .count (count)
  );

  generate
    for (genvar i = 0; i < NUM_IN; i++) begin : g_line
      edge_evt_t evt;

      est_input_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (pulse_in[i]),
        .evt (evt)
      );

      assign rise_det[i] = evt.rise;
      assign fall_det[i] = evt.fall;

      est_stamp_slot #(.W(TS_W)) u_slot (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .now       (count),
        .clr_rise  (rise_clr[i]),
        .clr_fall  (fall_clr[i]),
        .rise_ts   (rise_bus[i*TS_W +: TS_W]),
        .fall_ts   (fall_bus[i*TS_W +: TS_W]),
        .rise_seen (rise_flag[i]),
        .fall_seen (fall_flag[i])
      );
    end
  endgenerate

  assign rise_stamp = rise_bus;
  assign fall_stamp = fall_bus;

  est_snapshot #(.W(TS_W)) u_snap (
    .clk  (clk),
    .rst  (rst),
    .take (snap_req),
    .now  (count),
    .held (snap_value)
  );

endmodule

// File: rtl/est_checker.sv
module est_checker #(
  parameter int N = 3,
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst,
  input logic [W-1:0]   count,
  input logic [N-1:0]   rise_det,
  input logic [N-1:0]   fall_det,
  input logic [N-1:0]   rise_clr,
  input logic [N-1:0]   fall_clr,
  input logic [N*W-1:0] rise_stamp,
  input logic [N*W-1:0] fall_stamp,
  input logic [N-1:0]   rise_flag,
  input logic [N-1:0]   fall_flag,
  input logic           snap_req,
  input logic [W-1:0]   snap_value
);

  p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> count == $past(count) + 1'b1);

  p_snap_take_r9: assert property (@(posedge clk) disable iff (rst)
    snap_req |=> snap_value == $past(count));

  p_snap_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !snap_req |=> $stable(snap_value));

  generate
    for (genvar i = 0; i < N; i++) begin : g_chk
      p_rise_stamp_r3: assert property (@(posedge clk) disable iff (rst)
        rise_det[i] |=> rise_stamp[i*W +: W] == $past(count));

      p_fall_stamp_r3: assert property (@(posedge clk) disable iff (rst)
        fall_det[i] |=> fall_stamp[i*W +: W] == $past(count));

      p_rise_keep_r5: assert property (@(posedge clk) disable iff (rst)
        !rise_det[i] |=> $stable(rise_stamp[i*W +: W]));

      p_fall_keep_r5: assert property (@(posedge clk) disable iff (rst)
        !fall_det[i] |=> $stable(fall_stamp[i*W +: W]));

      p_rise_set_r8: assert property (@(posedge clk) disable iff (rst)
        rise_det[i] |=> rise_flag[i]);

      p_fall_set_r8: assert property (@(posedge clk) disable iff (rst)
        fall_det[i] |=> fall_flag[i]);

      p_rise_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (rise_clr[i] && !rise_det[i]) |=> !rise_flag[i]);

      p_fall_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (fall_clr[i] && !fall_det[i]) |=> !fall_flag[i]);

      p_rise_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (rise_flag[i] && !rise_clr[i]) |=> rise_flag[i]);

      p_one_kind_r3: assert property (@(posedge clk) disable iff (rst)
        !(rise_det[i] && fall_det[i]));
    end
  endgenerate

endmodule

bind edge_stamp_unit est_checker #(.N(NUM_IN), .W(TS_W)) u_est_chk (
  .clk        (clk),
  .rst        (rst),
  .count      (count),
  .rise_det   (rise_det),
  .fall_det   (fall_det),
  .rise_clr   (rise_clr),
  .fall_clr   (fall_clr),
  .rise_stamp (rise_stamp),
  .fall_stamp (fall_stamp),
  .rise_flag  (rise_flag),
  .fall_flag  (fall_flag),
  .snap_req   (snap_req),
  .snap_value (snap_value)
);

// File: tb/tb_edge_stamp_unit.sv
`timescale 1ns/1ps
module tb_edge_stamp_unit;

  localparam int NIN  = 3;
  localparam int TSW  = 12;  // small width so the wrap is reached quickly
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NIN-1:0]     pulse_in = '0;
  logic               snap_req = 1'b0;
  logic [NIN-1:0]     rise_clr = '0;
  logic [NIN-1:0]     fall_clr = '0;
  logic [NIN*TSW-1:0] rise_stamp;
  logic [NIN*TSW-1:0] fall_stamp;
  logic [NIN-1:0]     rise_flag;
  logic [NIN-1:0]     fall_flag;
  logic [TSW-1:0]     snap_value;

  always #4 clk = ~clk;  // 125 MHz

  edge_stamp_unit #(.NUM_IN(NIN), .TS_W(TSW), .SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst(rst), .pulse_in(pulse_in), .snap_req(snap_req),
    .rise_clr(rise_clr), .fall_clr(fall_clr),
    .rise_stamp(rise_stamp), .fall_stamp(fall_stamp),
    .rise_flag(rise_flag), .fall_flag(fall_flag), .snap_value(snap_value)
  );

  // Reference cycle counter, built from R1.
  logic [TSW-1:0] tb_cnt;
  always @(posedge clk) begin
    if (rst) tb_cnt <= '0;
    else     tb_cnt <= tb_cnt + 1'b1;
  end

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [TSW-1:0] rs(input int ch);
    return rise_stamp[ch*TSW +: TSW];
  endfunction
  function automatic logic [TSW-1:0] fs(input int ch);
    return fall_stamp[ch*TSW +: TSW];
  endfunction

  // Scoreboard: one queue per line and kind (index ch*2 + kind).
  logic [TSW-1:0] expq [2*NIN][$];
  logic [TSW-1:0] prev_r [NIN];
  logic [TSW-1:0] prev_f [NIN];

  // Driver: called at a falling edge; pushes the stamp expected by R2.
  task automatic drive_lines(input logic [NIN-1:0] val);
    for (int ch = 0; ch < NIN; ch++) begin
      if (val[ch] != pulse_in[ch]) begin
        expq[ch*2 + (val[ch] ? 0 : 1)].push_back(tb_cnt + TSW'(SYNC));
      end
    end
    pulse_in = val;
  endtask

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // Monitor: pops and compares whenever a stamp changes (R2, R3, R4, R5, R6).
  always @(negedge clk) begin
    if (rst) begin
      for (int ch = 0; ch < NIN; ch++) begin
        prev_r[ch] = '0;
        prev_f[ch] = '0;
      end
    end else begin
      for (int ch = 0; ch < NIN; ch++) begin
        if (rs(ch) != prev_r[ch]) begin
          if (expq[ch*2].size() == 0)
            chk(1'b0, "R5", $sformatf("unexpected rise stamp line %0d", ch), rs(ch), prev_r[ch]);
          else begin
            logic [TSW-1:0] e;
            e = expq[ch*2].pop_front();
            chk(rs(ch) == e, "R2", $sformatf("rise stamp line %0d", ch), rs(ch), e);
          end
          chk(rise_flag[ch], "R6", $sformatf("rise flag line %0d", ch), rise_flag[ch], 1);
          prev_r[ch] = rs(ch);
        end
        if (fs(ch) != prev_f[ch]) begin
          if (expq[ch*2+1].size() == 0)
            chk(1'b0, "R5", $sformatf("unexpected fall stamp line %0d", ch), fs(ch), prev_f[ch]);
          else begin
            logic [TSW-1:0] e;
            e = expq[ch*2+1].pop_front();
            chk(fs(ch) == e, "R3", $sformatf("fall stamp line %0d", ch), fs(ch), e);
          end
          chk(fall_flag[ch], "R6", $sformatf("fall flag line %0d", ch), fall_flag[ch], 1);
          prev_f[ch] = fs(ch);
        end
      end
    end
  end

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [TSW-1:0] e, a, b, r0, f0;
    cycles(4);
    rst = 1'b0;
    @(negedge clk);

    // R10: reset state
    chk(rise_stamp == '0 && fall_stamp == '0, "R10", "stamps after reset", rise_stamp[31:0], 0);
    chk(rise_flag == '0 && fall_flag == '0, "R10", "flags after reset", {rise_flag, fall_flag}, 0);
    chk(snap_value == '0, "R10", "snapshot after reset", snap_value, 0);

    // R9: snapshot take and hold
    snap_req = 1'b1; e = tb_cnt;
    @(negedge clk); snap_req = 1'b0;
    chk(snap_value == e, "R9", "snapshot value", snap_value, e);
    cycles(5);
    chk(snap_value == e, "R9", "snapshot held", snap_value, e);

    // R11: single pulse on line 0, width 7
    drive_lines(3'b001); cycles(7); drive_lines(3'b000); cycles(SYNC + 2);
    chk(TSW'(fs(0) - rs(0)) == 7, "R11", "line 0 high time", TSW'(fs(0) - rs(0)), 7);

    // R3 and R11: all lines rise together, fall at 3, 5, 9 cycles
    drive_lines(3'b111); cycles(3);
    drive_lines(3'b110); cycles(2);
    drive_lines(3'b100); cycles(4);
    drive_lines(3'b000); cycles(SYNC + 2);
    chk(rs(0) == rs(1) && rs(1) == rs(2), "R3", "simultaneous rises", rs(2), rs(0));
    chk(TSW'(fs(0) - rs(0)) == 3, "R11", "line 0 duty", TSW'(fs(0) - rs(0)), 3);
    chk(TSW'(fs(1) - rs(1)) == 5, "R11", "line 1 duty", TSW'(fs(1) - rs(1)), 5);
    chk(TSW'(fs(2) - rs(2)) == 9, "R11", "line 2 duty", TSW'(fs(2) - rs(2)), 9);

    // R4: two pulses on line 1, only the latest kept; low time from stamps
    drive_lines(3'b010); cycles(4); drive_lines(3'b000); cycles(6);
    a = tb_cnt + TSW'(SYNC);
    drive_lines(3'b010); cycles(2); drive_lines(3'b000); cycles(SYNC + 2);
    chk(rs(1) == a, "R4", "latest rise kept line 1", rs(1), a);
    chk(TSW'(fs(1) - rs(1)) == 2, "R4", "latest pulse width line 1", TSW'(fs(1) - rs(1)), 2);

    // R7: clear one rising flag, others untouched
    r0 = rs(0); f0 = fs(0);
    rise_clr = 3'b001; @(negedge clk); rise_clr = '0;
    chk(rise_flag == 3'b110, "R7", "rise flags after clear of line 0", rise_flag, 3'b110);
    chk(fall_flag == 3'b111, "R7", "fall flags untouched", fall_flag, 3'b111);
    chk(rs(0) == r0 && fs(0) == f0, "R7", "stamps untouched by clear", rs(0), r0);
    fall_clr = 3'b111; @(negedge clk); fall_clr = '0;
    chk(fall_flag == 3'b000, "R7", "all fall flags cleared", fall_flag, 0);

    // R8: clear lands in the capture cycle of line 2 rise
    rise_clr = 3'b100; @(negedge clk); rise_clr = '0;
    chk(rise_flag[2] == 1'b0, "R7", "line 2 rise flag cleared", rise_flag[2], 0);
    drive_lines(3'b100); cycles(SYNC);
    rise_clr = 3'b100; @(negedge clk); rise_clr = '0;
    chk(rise_flag[2] == 1'b1, "R8", "capture wins over clear", rise_flag[2], 1);
    drive_lines(3'b000); cycles(SYNC + 2);

    // R1: counter step seen through snapshots, back to back and 10 apart
    snap_req = 1'b1; a = tb_cnt;
    @(negedge clk); b = tb_cnt;
    chk(snap_value == a, "R9", "first back-to-back snapshot", snap_value, a);
    @(negedge clk); snap_req = 1'b0;
    chk(snap_value == b && TSW'(b - a) == 1, "R1", "counter step of one", snap_value, b);
    cycles(9);
    snap_req = 1'b1; @(negedge clk); snap_req = 1'b0;
    chk(TSW'(snap_value - b) == 10, "R1", "counter advance over 10 cycles", TSW'(snap_value - b), 10);

    // R1 and R11: pulse straddling the counter wrap
    while (tb_cnt != TSW'(4080)) @(negedge clk);
    drive_lines(3'b001); cycles(30); drive_lines(3'b000); cycles(SYNC + 2);
    chk(rs(0) > fs(0), "R1", "counter wrapped inside pulse", fs(0), rs(0));
    chk(TSW'(fs(0) - rs(0)) == 30, "R11", "width across wrap", TSW'(fs(0) - rs(0)), 30);

    cycles(4);
    for (int q = 0; q < 2*NIN; q++)
      chk(expq[q].size() == 0, "R2", $sformatf("stamps missing in queue %0d", q), expq[q].size(), 0);

    done = 1'b1;
    finish_run();
  end

endmodule